// File: doc/BRIEF.md
# Coupled Processor Restart Controller

This block lets a controlling processor restart a second, halted processor to which it is coupled. The controller issues a start command carrying three option bits. When the coupling mode is active and the remote processor is stopped, the block raises a start level, plus a skip level and a transfer level if those options were asked for. The levels stay up until the remote processor reports its first instruction cycle.

On the remote side, the block frees the remote processor from its stop with a one-cycle restart pulse, but only when the remote mode switch is set to automatic. Together with the pulse it gives the address to fetch next. That address is the address field of the halting instruction, the sequential program counter, or that counter plus one. The choice depends on what stopped the processor and on the options held. The trap-enable option sets a level that stays set until reset.

A sequencer with three states controls the block:
- `ST_IDLE`: no start is pending.
- `ST_ARMED`: the levels are latched and the restart has not yet been issued.
- `ST_LAUNCHED`: the restart has been issued and the block waits for the remote instruction cycle.

The transitions are:
- idle to armed: an accepted command.
- armed to launched: automatic mode with the remote processor stopped.
- armed to idle, or launched to idle: the remote instruction cycle.

Top module: `remote_start_ctl`

## Requirements
- R1: After reset, start_lvl, skip_lvl, xfer_lvl, trap_en, restart, cmd_done and proto_err are all low.
- R2: Every command (cmd_valid high for one cycle) gives a cmd_done pulse in the following cycle, in every mode and state.
- R3: With mp_mode low, a command raises no level, no trap enable, no restart and no protocol error.
- R4: The option bits are cmd_opt[0] = skip, cmd_opt[1] = transfer and cmd_opt[2] = trap enable. A command accepted in ST_IDLE, with mp_mode high and remote_run low, raises start_lvl in the next cycle. It also raises skip_lvl and xfer_lvl according to bits 0 and 1.
- R5: The latched levels stay high until a cycle with rem_icycle high. In the following cycle all three levels are low.
- R6: restart is high for exactly one cycle. It is high only in ST_ARMED, with auto_sw high and remote_run low. While auto_sw is low no restart happens and the levels remain held. Setting auto_sw high later produces the restart at that point.
- R7: When halt_cause is 2'b01 (halt-and-transfer), fetch_addr during restart equals halt_addr, even if skip was requested.
- R8: For halt_cause 2'b00 (plain halt), 2'b10 (divide check) or 2'b11 (I/O stop) with no transfer requested, fetch_addr equals seq_pc, plus one modulo 2^AW when skip_lvl is set.
- R9: A transfer request gives fetch_addr = halt_addr for any halt cause, and wins over skip when both bits are set (option code 3).
- R10: A command given while remote_run is high produces no levels and no restart. Its only lasting effect is on trap_en.
- R11: A command in mp_mode with remote_run high and skip or transfer set gives a proto_err pulse in the following cycle.
- R12: trap_en is set by any command in mp_mode with bit 2 set, in any state, and stays set until reset. A command that arrives while levels are held leaves skip_lvl and xfer_lvl unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mp_mode | input | 1 | Coupling (multiprocess) mode active |
| auto_sw | input | 1 | Remote mode switch, 1 = automatic |
| remote_run | input | 1 | Remote processor is executing |
| rem_icycle | input | 1 | Remote instruction-cycle acknowledge |
| halt_cause | input | 2 | Why the remote stopped (see R7, R8) |
| halt_addr | input | AW | Address field of the halting instruction |
| seq_pc | input | AW | Remote sequential program counter |
| cmd_valid | input | 1 | Start command strobe |
| cmd_opt | input | 3 | Start option bits |
| cmd_done | output | 1 | Command completed on the controller side |
| start_lvl | output | 1 | Start level to the remote side |
| skip_lvl | output | 1 | Skip level |
| xfer_lvl | output | 1 | Transfer level |
| trap_en | output | 1 | Traps from the controller enabled |
| restart | output | 1 | One-cycle clear of the remote stop |
| fetch_addr | output | AW | Next fetch address, valid with restart |
| proto_err | output | 1 | Skip/transfer sent to a running remote |

## Verification
The assertions assume that cmd_valid lasts a single cycle. They assume that rem_icycle is raised only after a restart or a manual start, and that halt_cause, halt_addr and seq_pc stay steady while a restart is pending. The stimulus keeps to these rules. It changes the remote inputs only between commands, and it ends each case with one acknowledge pulse. Every combination of mode, run state, switch, halt cause and option code is covered in this way.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    typedef enum logic [1:0] {
        HC_HALT   = 2'b00,
        HC_HTR    = 2'b01,
        HC_DIVCK  = 2'b10,
        HC_IOSTOP = 2'b11
    } halt_cause_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_LAUNCHED
    } seq_state_t;

    typedef struct packed {
        logic trap;
        logic xfer;
        logic skip;
    } start_opt_t;

    localparam int OPT_W = 3;
endpackage

// File: rtl/rsc_opt_decode.sv
module rsc_opt_decode
    import rsc_pkg::*;
(
    input  logic             cmd_valid,
    input  logic [OPT_W-1:0] cmd_opt,
    input  logic             mp_mode,
    input  logic             remote_run,
    output start_opt_t       opt,
    output logic             accept,
    output logic             trap_set,
    output logic             bad_req
);
    always_comb begin
        opt      = start_opt_t'(cmd_opt);
        accept   = cmd_valid && mp_mode && !remote_run;
        trap_set = cmd_valid && mp_mode && opt.trap;
        bad_req  = cmd_valid && mp_mode && remote_run && (opt.skip || opt.xfer);
    end
endmodule

// File: rtl/rsc_fetch_sel.sv
module rsc_fetch_sel
    import rsc_pkg::*;
#(
    parameter int AW = 15
) (
    input  halt_cause_t   cause,
    input  logic          skip,
    input  logic          xfer,
    input  logic [AW-1:0] halt_addr,
    input  logic [AW-1:0] seq_pc,
    output logic [AW-1:0] fetch_addr
);
    localparam logic [AW-1:0] ONE = AW'(1);

    always_comb begin
        if (xfer || cause == HC_HTR)
            fetch_addr = halt_addr;
        else if (skip)
            fetch_addr = seq_pc + ONE;
        else
            fetch_addr = seq_pc;
    end
endmodule

// File: rtl/rsc_seq.sv
module rsc_seq
    import rsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  start_opt_t opt,
    input  logic       accept,
    input  logic       trap_set,
    input  logic       bad_req,
    input  logic       rem_icycle,
    input  logic       auto_sw,
    input  logic       remote_run,
    output logic       start_lvl,
    output logic       skip_lvl,
    output logic       xfer_lvl,
    output logic       trap_en,
    output logic       cmd_done,
    output logic       proto_err,
    output logic       restart
);
    seq_state_t state_q, state_d;
    logic skip_q, xfer_q, trap_q, done_q, err_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept) state_d = ST_ARMED;
            ST_ARMED: begin
                if (rem_icycle)                 state_d = ST_IDLE;
                else if (auto_sw && !remote_run) state_d = ST_LAUNCHED;
            end
            ST_LAUNCHED: if (rem_icycle) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            skip_q  <= 1'b0;
            xfer_q  <= 1'b0;
            trap_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= cmd_valid;
            err_q   <= bad_req;
            if (trap_set) trap_q <= 1'b1;
            if (state_q == ST_IDLE && accept) begin
                skip_q <= opt.skip;
                xfer_q <= opt.xfer;
            end else if (state_q != ST_IDLE && rem_icycle) begin
                skip_q <= 1'b0;
                xfer_q <= 1'b0;
            end
        end
    end

    always_comb begin
        start_lvl = (state_q != ST_IDLE);
        skip_lvl  = skip_q;
        xfer_lvl  = xfer_q;
        trap_en   = trap_q;
        cmd_done  = done_q;
        proto_err = err_q;
        restart   = (state_q == ST_ARMED) && auto_sw && !remote_run && !rem_icycle;
    end

    assert_levels_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_lvl && rem_icycle) |=> (!start_lvl && !skip_lvl && !xfer_lvl));
    assert_opts_need_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_lvl || xfer_lvl) |-> start_lvl);
    assert_restart_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !restart);
    assert_restart_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> (auto_sw && !remote_run && start_lvl));
    assert_trap_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        trap_en |=> trap_en);
endmodule

// File: rtl/remote_start_ctl.sv
module remote_start_ctl
    import rsc_pkg::*;
#(
    parameter int AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mp_mode,
    input  logic          auto_sw,
    input  logic          remote_run,
    input  logic          rem_icycle,
    input  logic [1:0]    halt_cause,
    input  logic [AW-1:0] halt_addr,
    input  logic [AW-1:0] seq_pc,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_opt,
    output logic          cmd_done,
    output logic          start_lvl,
    output logic          skip_lvl,
    output logic          xfer_lvl,
    output logic          trap_en,
    output logic          restart,
    output logic [AW-1:0] fetch_addr,
    output logic          proto_err
);
    start_opt_t  opt;
    logic        accept, trap_set, bad_req;
    halt_cause_t cause;

    assign cause = halt_cause_t'(halt_cause);

    rsc_opt_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_opt   (cmd_opt),
        .mp_mode   (mp_mode),
        .remote_run(remote_run),
        .opt       (opt),
        .accept    (accept),
        .trap_set  (trap_set),
        .bad_req   (bad_req)
    );

    rsc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .opt       (opt),
        .accept    (accept),
        .trap_set  (trap_set),
        .bad_req   (bad_req),
        .rem_icycle(rem_icycle),
        .auto_sw   (auto_sw),
        .remote_run(remote_run),
        .start_lvl (start_lvl),
        .skip_lvl  (skip_lvl),
        .xfer_lvl  (xfer_lvl),
        .trap_en   (trap_en),
        .cmd_done  (cmd_done),
        .proto_err (proto_err),
        .restart   (restart)
    );

    rsc_fetch_sel #(.AW(AW)) u_sel (
        .cause     (cause),
        .skip      (skip_lvl),
        .xfer      (xfer_lvl),
        .halt_addr (halt_addr),
        .seq_pc    (seq_pc),
        .fetch_addr(fetch_addr)
    );

    assert_htr_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && cause == HC_HTR) |-> fetch_addr == halt_addr);
    assert_xfer_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && xfer_lvl) |-> fetch_addr == halt_addr);
    assert_running_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && mp_mode && remote_run && (cmd_opt[0] || cmd_opt[1])) |=> proto_err);
    assert_no_mode_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !mp_mode && !start_lvl) |=> !start_lvl);
    assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> cmd_done);
endmodule

// File: tb/sim_remote_start_ctl.sv
`timescale 1ns/1ps
module sim_remote_start_ctl;
    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mp_mode = 1'b0, auto_sw = 1'b0, remote_run = 1'b0, rem_icycle = 1'b0;
    logic [1:0]    halt_cause = 2'b00;
    logic [AW-1:0] halt_addr = '0, seq_pc = '0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_opt = 3'b000;
    logic          cmd_done, start_lvl, skip_lvl, xfer_lvl, trap_en, restart, proto_err;
    logic [AW-1:0] fetch_addr;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit trap_model = 0;

    always #2.5 clk = ~clk;

    remote_start_ctl #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .mp_mode(mp_mode), .auto_sw(auto_sw),
        .remote_run(remote_run), .rem_icycle(rem_icycle), .halt_cause(halt_cause),
        .halt_addr(halt_addr), .seq_pc(seq_pc), .cmd_valid(cmd_valid), .cmd_opt(cmd_opt),
        .cmd_done(cmd_done), .start_lvl(start_lvl), .skip_lvl(skip_lvl), .xfer_lvl(xfer_lvl),
        .trap_en(trap_en), .restart(restart), .fetch_addr(fetch_addr), .proto_err(proto_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        trap_model = 0;
        #1;
        chk(!start_lvl && !skip_lvl && !xfer_lvl, "R1 levels", {start_lvl, skip_lvl, xfer_lvl}, 0);
        chk(!trap_en && !restart && !cmd_done && !proto_err, "R1 misc",
            {trap_en, restart, cmd_done, proto_err}, 0);
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        rem_icycle = 1'b1;
        @(negedge clk);
        rem_icycle = 1'b0;
        #1;
        chk(!start_lvl && !skip_lvl && !xfer_lvl, "R5 release", {start_lvl, skip_lvl, xfer_lvl}, 0);
    endtask

    task automatic run_case(input bit mp, input bit run, input bit aut, input logic [1:0] cause,
                            input logic [2:0] code, input int idx);
        bit acc, exp_err;
        logic [AW-1:0] exp_addr;
        @(negedge clk);
        mp_mode = mp; remote_run = run; auto_sw = aut; halt_cause = cause;
        halt_addr = AW'(idx * 1234 + 7);
        seq_pc = (idx % 5 == 0) ? '1 : AW'(idx * 37);
        cmd_opt = code;
        cmd_valid = 1'b1;
        acc = mp && !run;
        exp_err = mp && run && (code[0] || code[1]);
        if (mp && code[2]) trap_model = 1;
        exp_addr = (code[1] || cause == 2'b01) ? halt_addr : (seq_pc + AW'(code[0]));
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        chk(cmd_done == 1'b1, "R2 done", cmd_done, 1);
        chk(start_lvl == acc, mp ? "R10 start" : "R3 start", start_lvl, acc);
        chk(skip_lvl == (acc && code[0]) && xfer_lvl == (acc && code[1]), "R4 options",
            {skip_lvl, xfer_lvl}, {acc && code[0], acc && code[1]});
        chk(proto_err == exp_err, "R11 error", proto_err, exp_err);
        chk(trap_en == trap_model, "R12 trap", trap_en, trap_model);
        chk(restart == (acc && aut), "R6 restart", restart, acc && aut);
        if (acc && aut)
            chk(fetch_addr == exp_addr, code[1] ? "R9 addr" : (cause == 2'b01 ? "R7 addr" : "R8 addr"),
                fetch_addr, exp_addr);
        @(negedge clk);
        #1;
        chk(restart == 1'b0 && cmd_done == 1'b0, "R6 single", {restart, cmd_done}, 0);
        chk(start_lvl == acc, "R5 held", start_lvl, acc);
        if (acc && !aut) begin
            auto_sw = 1'b1;
            #1;
            chk(restart == 1'b1, "R6 late auto", restart, 1);
            chk(fetch_addr == exp_addr, "R8 late addr", fetch_addr, exp_addr);
            @(negedge clk);
            #1;
            chk(restart == 1'b0, "R6 late single", restart, 0);
        end
        pulse_ack();
    endtask

    initial begin
        do_reset();
        for (int i = 0; i < 256; i++) begin
            if (i == 128) do_reset();
            run_case(i[7], i[6], i[5], i[4:3], i[2:0], i);
        end
        do_reset();
        // R12: a second command while levels are held does not touch them
        run_hold: begin
            @(negedge clk);
            mp_mode = 1; remote_run = 0; auto_sw = 0; halt_cause = 2'b00;
            cmd_opt = 3'b010; cmd_valid = 1;
            @(negedge clk);
            cmd_opt = 3'b101;
            @(negedge clk);
            cmd_valid = 0;
            #1;
            chk(skip_lvl == 0 && xfer_lvl == 1, "R12 held opts", {skip_lvl, xfer_lvl}, 2'b01);
            chk(trap_en == 1 && cmd_done == 1, "R12 trap while held", {trap_en, cmd_done}, 2'b11);
            pulse_ack();
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule